// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the wall-clock time and the calendar date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-cycle tick enable from an external prescaler advances it by one second. It is meant to sit under a register front end that reads the seven bytes and writes them through a simple load port. The same front end drives an oscillator-stop input that freezes the count.

The hours byte carries its own format. Bit 6 set selects a 12-hour clock with bit 5 as the afternoon flag. Bit 6 clear gives a 24-hour clock in which bit 5 is the upper tens-of-hours bit. The day of month wraps at the true length of each month, and February gets 29 days in every year divisible by four, year 00 included. Each counted second also raises a single-cycle pulse, aligned with the updated time, for use by an alarm comparator.

Top module: `tk_calendar`

## Requirements
- R1: After synchronous reset the time reads 00:00:00 in 24-hour format, with weekday 01, date 01, month 01 and year 00, and the second pulse is low.
- R2: Seconds and minutes count 00 to 59 in BCD. Each wraps from 59 to 00 and carries into the next field.
- R3: In 24-hour format (hours bit 6 = 0) the hour counts 00 to 23 in BCD. It wraps from 23 to 00 and carries into the date and weekday.
- R4: In 12-hour format (hours bit 6 = 1, bit 5 = PM, hour value 01-12 in bits 4:0), 11 rolls to 12 and toggles bit 5, and 12 rolls to 01 with bit 5 unchanged. The date and weekday advance only on the roll from 11 PM to 12 AM.
- R5: The weekday counts 01 to 07 and wraps to 01 at each day carry.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Each such wrap advances the month.
- R7: In February the date wraps after 29 when the BCD year is divisible by four (00 included) and after 28 otherwise.
- R8: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R9: While the oscillator-stop input is 1, ticks are ignored and no field changes except through writes.
- R10: A write loads the field chosen by the select code (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year; 7 selects nothing). Unused bits read 0: masks 7F for seconds, minutes and hours, 07 for weekday, 3F for date, 1F for month and FF for year.
- R11: A write in the same cycle as a counted tick wins for the written field. The other fields still advance, with carries taken from the values held before that cycle.
- R12: The second pulse is high for one cycle, in the cycle after each tick that arrives while the oscillator-stop input is 0, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-second advance enable, one cycle wide |
| osc_stop | input | 1 | 1 freezes counting, 0 runs |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD write value |
| secs_q | output | 8 | Seconds, BCD |
| mins_q | output | 8 | Minutes, BCD |
| hours_q | output | 8 | Hours byte with format and PM bits |
| wday_q | output | 8 | Day of week 01-07 |
| date_q | output | 8 | Day of month, BCD |
| month_q | output | 8 | Month, BCD |
| year_q | output | 8 | Year 00-99, BCD |
| sec_pulse | output | 1 | One-cycle pulse per counted second |

## Verification
The bench builds the block with its default boot values, so reset lands on 1 January of year 00, a leap year. Every date, month and year corner is reached within a few cycles by writing the fields just before a rollover and then sending one tick. This gives the month-end, leap February, non-leap February, year wrap and both meridian transitions without counting through real time.

// File: rtl/tk_cal_pkg.sv
package tk_cal_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 7;
    localparam int SEL_W      = $clog2(NUM_FIELDS + 1);

    typedef enum logic [SEL_W-1:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_WDAY  = 3'd3,
        F_DATE  = 3'd4,
        F_MONTH = 3'd5,
        F_YEAR  = 3'd6,
        F_NONE  = 3'd7
    } field_e;

    typedef struct packed {
        logic [FIELD_W-1:0] year;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] wday;
        logic [FIELD_W-1:0] hours;
        logic [FIELD_W-1:0] mins;
        logic [FIELD_W-1:0] secs;
    } cal_t;

    // Two-digit packed BCD increment (no range wrap).
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [FIELD_W-1:0] field_mask(input int idx);
        case (idx)
            0, 1, 2: return 8'h7F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] field_lo(input int idx);
        case (idx)
            3, 4, 5: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] field_hi(input int idx);
        case (idx)
            0, 1:    return 8'h59;
            2:       return 8'h23;
            3:       return 8'h07;
            4:       return 8'h31;
            5:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    // BCD year divisible by four: even tens need units 0/4/8, odd tens need 2/6.
    function automatic logic leap_year(input logic [FIELD_W-1:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

endpackage

// File: rtl/tk_month_len.sv
module tk_month_len
    import tk_cal_pkg::*;
(
    input  logic [FIELD_W-1:0] month,
    input  logic [FIELD_W-1:0] year,
    output logic [FIELD_W-1:0] last_date
);
    always_comb begin
        case (month)
            8'h02:                      last_date = leap_year(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/tk_bcd_field.sv
module tk_bcd_field
    import tk_cal_pkg::*;
#(
    parameter logic [FIELD_W-1:0] MASK = 8'hFF,
    parameter logic [FIELD_W-1:0] LO   = 8'h00,
    parameter logic [FIELD_W-1:0] RSTV = 8'h00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               ld,
    input  logic [FIELD_W-1:0] ld_val,
    input  logic [FIELD_W-1:0] top,
    output logic [FIELD_W-1:0] q,
    output logic               wrap
);
    logic [FIELD_W-1:0] q_next;

    always_comb begin
        wrap = step && (q >= top);
        if (ld)
            q_next = ld_val & MASK;
        else if (wrap)
            q_next = LO;
        else if (step)
            q_next = bcd_inc(q) & MASK;
        else
            q_next = q;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RSTV;
        else     q <= q_next;
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!step && !ld) |=> $stable(q));

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
        ld |=> ((q & ~MASK) == '0));

    assert_wrap_low_R2: assert property (@(posedge clk) disable iff (rst)
        (wrap && !ld) |=> (q == LO));
endmodule

// File: rtl/tk_hour_field.sv
module tk_hour_field
    import tk_cal_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RSTV = 8'h00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               ld,
    input  logic [FIELD_W-1:0] ld_val,
    output logic [FIELD_W-1:0] q,
    output logic               day_carry
);
    localparam logic [FIELD_W-1:0] MASK = field_mask(int'(F_HOUR));

    logic               fmt12;
    logic               pm;
    logic [FIELD_W-1:0] inc12;
    logic [FIELD_W-1:0] inc24;
    logic [FIELD_W-1:0] adv_val;
    logic [FIELD_W-1:0] q_next;

    always_comb begin
        fmt12 = q[6];
        pm    = q[5];
        inc12 = bcd_inc({3'b000, q[4:0]});
        inc24 = bcd_inc({2'b00, q[5:0]});

        if (fmt12) begin
            day_carry = step && pm && (q[4:0] == 5'h11);
            if (q[4:0] >= 5'h12)
                adv_val = {2'b01, pm, 5'h01};
            else if (q[4:0] == 5'h11)
                adv_val = {2'b01, ~pm, 5'h12};
            else
                adv_val = {2'b01, pm, inc12[4:0]};
        end else begin
            day_carry = step && (q[5:0] >= 6'h23);
            if (q[5:0] >= 6'h23)
                adv_val = 8'h00;
            else
                adv_val = {2'b00, inc24[5:0]};
        end

        if (ld)        q_next = ld_val & MASK;
        else if (step) q_next = adv_val;
        else           q_next = q;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RSTV;
        else     q <= q_next;
    end

    assert_meridian_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && q[6] && q[4:0] == 5'h11) |=> (q[4:0] == 5'h12) && (q[5] != $past(q[5])));

    assert_twelve_to_one_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && q[6] && q[4:0] == 5'h12) |=> (q[4:0] == 5'h01) && $stable(q[6:5]));

    assert_midnight_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && !q[6] && q[5:0] == 6'h23) |=> (q == 8'h00));
endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
    import tk_cal_pkg::*;
#(
    parameter logic [7:0] BOOT_YEAR  = 8'h00,
    parameter logic [7:0] BOOT_MONTH = 8'h01,
    parameter logic [7:0] BOOT_DATE  = 8'h01,
    parameter logic [7:0] BOOT_WDAY  = 8'h01
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       osc_stop,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] secs_q,
    output logic [7:0] mins_q,
    output logic [7:0] hours_q,
    output logic [7:0] wday_q,
    output logic [7:0] date_q,
    output logic [7:0] month_q,
    output logic [7:0] year_q,
    output logic       sec_pulse
);
    logic               run;
    logic [FIELD_W-1:0] q    [NUM_FIELDS];
    logic               wrap [NUM_FIELDS];
    logic               adv  [NUM_FIELDS];
    logic               ld   [NUM_FIELDS];
    logic [FIELD_W-1:0] last_date;
    cal_t               now;

    assign run = tick_en && !osc_stop;

    // Carry chain: sec -> min -> hour -> {weekday, date}; date -> month -> year.
    assign adv[F_SEC]   = run;
    assign adv[F_MIN]   = wrap[F_SEC];
    assign adv[F_HOUR]  = wrap[F_MIN];
    assign adv[F_WDAY]  = wrap[F_HOUR];
    assign adv[F_DATE]  = wrap[F_HOUR];
    assign adv[F_MONTH] = wrap[F_DATE];
    assign adv[F_YEAR]  = wrap[F_MONTH];

    tk_month_len i_month_len (
        .month     (q[F_MONTH]),
        .year      (q[F_YEAR]),
        .last_date (last_date)
    );

    function automatic logic [FIELD_W-1:0] boot_val(input int idx);
        case (idx)
            3:       return BOOT_WDAY;
            4:       return BOOT_DATE;
            5:       return BOOT_MONTH;
            6:       return BOOT_YEAR;
            default: return 8'h00;
        endcase
    endfunction

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign ld[i] = wr_en && (wr_sel == 3'(i));
        if (i == int'(F_HOUR)) begin : g_hour
            tk_hour_field #(.RSTV(boot_val(i))) i_hour (
                .clk       (clk),
                .rst       (rst),
                .step      (adv[i]),
                .ld        (ld[i]),
                .ld_val    (wr_data),
                .q         (q[i]),
                .day_carry (wrap[i])
            );
        end else begin : g_plain
            tk_bcd_field #(
                .MASK (field_mask(i)),
                .LO   (field_lo(i)),
                .RSTV (boot_val(i))
            ) i_fld (
                .clk    (clk),
                .rst    (rst),
                .step   (adv[i]),
                .ld     (ld[i]),
                .ld_val (wr_data),
                .top    ((i == int'(F_DATE)) ? last_date : field_hi(i)),
                .q      (q[i]),
                .wrap   (wrap[i])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sec_pulse <= 1'b0;
        else     sec_pulse <= run;
    end

    always_comb begin
        now.secs  = q[F_SEC];
        now.mins  = q[F_MIN];
        now.hours = q[F_HOUR];
        now.wday  = q[F_WDAY];
        now.date  = q[F_DATE];
        now.month = q[F_MONTH];
        now.year  = q[F_YEAR];
    end

    assign secs_q  = now.secs;
    assign mins_q  = now.mins;
    assign hours_q = now.hours;
    assign wday_q  = now.wday;
    assign date_q  = now.date;
    assign month_q = now.month;
    assign year_q  = now.year;

    assert_pulse_source_R12: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |-> $past(tick_en && !osc_stop));

    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (osc_stop && !wr_en) |=> $stable(now));

    assert_leap_feb_R7: assert property (@(posedge clk) disable iff (rst)
        (adv[F_DATE] && !wr_en && now.month == 8'h02 && now.date == 8'h28 && leap_year(now.year))
        |=> (now.date == 8'h29));

    assert_year_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (adv[F_YEAR] && !wr_en && now.year == 8'h99) |=> (now.year == 8'h00));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (run && wr_en && wr_sel == 3'(F_SEC)) |=> (now.secs == ($past(wr_data) & 8'h7F)));
endmodule

// File: tb/test_tk_calendar.sv
module test_tk_calendar;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       osc_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] secs_q, mins_q, hours_q, wday_q, date_q, month_q, year_q;
    logic       sec_pulse;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    logic [55:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tk_calendar i_tk_calendar (
        .clk (clk), .rst (rst), .tick_en (tick_en), .osc_stop (osc_stop),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .secs_q (secs_q), .mins_q (mins_q), .hours_q (hours_q), .wday_q (wday_q),
        .date_q (date_q), .month_q (month_q), .year_q (year_q), .sec_pulse (sec_pulse)
    );

    function automatic logic [55:0] pk(input logic [7:0] y, mo, d, wd, h, mi, s);
        return {y, mo, d, wd, h, mi, s};
    endfunction

    function automatic logic [55:0] snap();
        return {year_q, month_q, date_q, wday_q, hours_q, mins_q, secs_q};
    endfunction

    task automatic chk(input string req, input logic [55:0] got, input logic [55:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: every pulse pops one expected snapshot (R12 alignment).
    always @(negedge clk) begin
        if (!rst && sec_pulse) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R12: unexpected pulse got 1 expected 0");
            end else begin
                chk("scoreboard", snap(), exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] y, mo, d, wd, h, mi, s);
        wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd3, wd);
        wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
    endtask

    task automatic tick(input logic [55:0] exp);
        @(negedge clk);
        tick_en = 1'b1;
        exp_q.push_back(exp);
        @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick_wr(input logic [2:0] s, input logic [7:0] d, input logic [55:0] exp);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_sel = s; wr_data = d;
        exp_q.push_back(exp);
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset time", snap(), pk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
        chk("R1 pulse low", {55'd0, sec_pulse}, 56'd0);

        // R2 plain second, then R2 R3 R5 R8 full rollover
        tick(pk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01));
        set_all(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
        tick(pk(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59));
        tick(pk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));

        // R7 leap and non-leap February
        set_all(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        tick(pk(8'h24, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00));
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick(pk(8'h24, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00));
        set_all(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        tick(pk(8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00));
        set_all(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        tick(pk(8'h23, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));

        // R6 month ends
        set_all(8'h25, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        tick(pk(8'h25, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00));
        set_all(8'h25, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        tick(pk(8'h25, 8'h01, 8'h31, 8'h03, 8'h00, 8'h00, 8'h00));
        set_all(8'h25, 8'h11, 8'h30, 8'h06, 8'h23, 8'h59, 8'h59);
        tick(pk(8'h25, 8'h12, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00));

        // R4 12-hour transitions
        set_all(8'h25, 8'h06, 8'h10, 8'h03, 8'h51, 8'h59, 8'h59);
        tick(pk(8'h25, 8'h06, 8'h10, 8'h03, 8'h72, 8'h00, 8'h00));
        wr(3'd2, 8'h71); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick(pk(8'h25, 8'h06, 8'h11, 8'h04, 8'h52, 8'h00, 8'h00));
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick(pk(8'h25, 8'h06, 8'h11, 8'h04, 8'h41, 8'h00, 8'h00));
        wr(3'd2, 8'h72); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick(pk(8'h25, 8'h06, 8'h11, 8'h04, 8'h61, 8'h00, 8'h00));

        // R9 R12 oscillator stopped: ticks ignored, no pulse
        @(negedge clk);
        osc_stop = 1'b1;
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
        chk("R9 frozen", snap(), pk(8'h25, 8'h06, 8'h11, 8'h04, 8'h61, 8'h00, 8'h00));
        osc_stop = 1'b0;

        // R11 write wins over tick
        tick_wr(3'd0, 8'h45, pk(8'h25, 8'h06, 8'h11, 8'h04, 8'h61, 8'h00, 8'h45));
        wr(3'd0, 8'h59);
        tick_wr(3'd1, 8'h30, pk(8'h25, 8'h06, 8'h11, 8'h04, 8'h61, 8'h30, 8'h00));

        // R10 unused bits and the idle select code
        wr(3'd0, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd2, 8'hFF);
        @(negedge clk);
        chk("R10 masks", snap(), pk(8'h25, 8'h1F, 8'h3F, 8'h07, 8'h7F, 8'h30, 8'h7F));
        set_all(8'h25, 8'h06, 8'h11, 8'h04, 8'h10, 8'h20, 8'h30);
        wr(3'd7, 8'h00);
        @(negedge clk);
        chk("R10 select 7", snap(), pk(8'h25, 8'h06, 8'h11, 8'h04, 8'h10, 8'h20, 8'h30));

        repeat (3) @(negedge clk);
        chk("R12 all pulses seen", 56'(exp_q.size()), 56'd0);
        finish_up();
    end
endmodule